// File: doc/BRIEF.md
# Masked Pattern Detector with Autoreset

This block watches the value an accumulator is about to load into its result register and decides, under a mask, whether that value equals a chosen pattern, and separately whether it equals the bitwise inverse of that pattern. Both decisions are registered with the same clock enable as the accumulator's result register. The flags therefore describe the result the accumulator currently holds. A mask bit of 1 excludes that bit from both comparisons. The pattern comes either from a static parameter or from the dynamic C operand. The mask comes from a static parameter, from the C operand, or from C shifted left by one or two places (zero filled) and then inverted. The shifted forms support convergent rounding.

A small state machine keeps the detect history and drives a clear request back to the accumulator. The accumulator zeroes its result register at the next clock edge when the request is high. The clear policy is one of three: never, on a match, or on the first miss after a match. The first-miss policy makes the block usable as a terminal-count reset. A priority parameter sets whether the request ignores the accumulator clock enable or is gated by it. The accumulator arithmetic itself lies outside the block.

States of the machine: `ST_MISS` (the held result does not match), `ST_HIT` (the held result matches), and `ST_DROP` (the held result misses and the previously loaded result matched). Transitions on a load with no clear: `ST_MISS`/`ST_DROP` go to `ST_HIT` on a match and to `ST_MISS` on a miss. `ST_HIT` stays in `ST_HIT` on a match and goes to `ST_DROP` on a miss. Reset, or a clear request at the edge, sends any state to `ST_MISS`. With the enable low and no clear, the state holds.

Top module: `mpat_detect`

## Requirements
- R1: At an edge with `rst` low, `cep` high and `clr_req_o` low, `match_o` becomes 1 exactly when `((acc_d ^ pattern) & ~mask) == 0`. A mask bit of 1 means the bit is ignored.
- R2: Under the same load condition, `match_inv_o` becomes 1 exactly when `((acc_d ^ ~pattern) & ~mask) == 0`.
- R3: `PAT_SRC = PAT_FROM_PARAM` uses the parameter `PAT_VAL` as the pattern. `PAT_SRC = PAT_FROM_C` uses `c_op`.
- R4: `MASK_SRC` selects the mask as follows. `MSK_FROM_PARAM` uses `MASK_VAL`. `MSK_FROM_C` uses `c_op`. `MSK_RND_SH1` uses `~(c_op << 1)`. `MSK_RND_SH2` uses `~(c_op << 2)`. The vacated low bits are 0 before inversion, so those mask bits are 1 and are ignored.
- R5: By default the mask is `48'h3fffffffffff`, so only bits 47 and 46 are compared, and the pattern is all zeros.
- R6: The flags load only on an edge with `cep` high. With `cep` low and no clear they hold. They change one edge after the compared `acc_d`, in step with the accumulator's result register.
- R7: With `CLR_POL = CLR_NEVER`, `clr_req_o` stays 0.
- R8: With `CLR_POL = CLR_ON_MATCH`, the clear trigger is the registered match flag being 1.
- R9: With `CLR_POL = CLR_ON_MISS`, the clear trigger is that the held result misses while the previously loaded result matched (state `ST_DROP`).
- R10: With `CLR_PRIO = CLR_OVER_CE`, `clr_req_o` equals the trigger whatever `cep` is. With `CLR_PRIO = CE_GATES_CLR`, `clr_req_o` is the trigger ANDed with `cep`.
- R11: At an edge where `clr_req_o` is 1, both flags clear to 0 and the state returns to `ST_MISS`, matching the zeroed accumulator.
- R12: A synchronous active-high `rst` clears both flags and leaves `clr_req_o` at 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the accumulator |
| rst | input | 1 | Synchronous active-high reset |
| acc_d | input | W | Value the accumulator loads at this edge |
| c_op | input | W | C operand, source for dynamic pattern or mask |
| cep | input | 1 | Accumulator result-register clock enable |
| match_o | output | 1 | Registered masked match against the pattern |
| match_inv_o | output | 1 | Registered masked match against the inverted pattern |
| clr_req_o | output | 1 | Request to zero the accumulator at the next edge |

## Verification
Eight-bit copies of the detector are driven with every accumulator value against sixteen C values, each spaced 17 apart. The C values give distinct rounding masks, dynamic patterns and dynamic masks. This separates errors in the mask shift amount, the inversion, the fill of the vacated bits and the choice between pattern and inverted pattern. A clock enable that drops in a fixed rhythm tells holding apart from loading, and it tells the two priority settings apart when the enable is low while a clear is pending. Match runs ending in a miss separate the match and first-miss clear policies. A full-width instance with default parameters checks that only the top two bits are compared.

// File: rtl/mpat_pkg.sv
package mpat_pkg;

    typedef enum logic {
        PAT_FROM_PARAM,
        PAT_FROM_C
    } pat_src_e;

    typedef enum logic [1:0] {
        MSK_FROM_PARAM,
        MSK_FROM_C,
        MSK_RND_SH1,
        MSK_RND_SH2
    } mask_src_e;

    typedef enum logic [1:0] {
        CLR_NEVER,
        CLR_ON_MATCH,
        CLR_ON_MISS
    } clr_pol_e;

    typedef enum logic {
        CLR_OVER_CE,
        CE_GATES_CLR
    } clr_prio_e;

    typedef enum logic [1:0] {
        ST_MISS,
        ST_HIT,
        ST_DROP
    } det_state_e;

endpackage

// File: rtl/mpat_src_sel.sv
module mpat_src_sel
    import mpat_pkg::*;
#(
    parameter int        W        = 48,
    parameter pat_src_e  PAT_SRC  = PAT_FROM_PARAM,
    parameter mask_src_e MASK_SRC = MSK_FROM_PARAM,
    parameter logic [W-1:0] PAT_VAL  = '0,
    parameter logic [W-1:0] MASK_VAL = '1
) (
    input  logic [W-1:0] c_op,
    output logic [W-1:0] pat_o,
    output logic [W-1:0] mask_o
);

    localparam int SH1 = 1;
    localparam int SH2 = 2;

    logic [W-1:0] c_sh1;
    logic [W-1:0] c_sh2;

    // zero fill of the vacated bits happens before the inversion
    assign c_sh1 = {c_op[W-1-SH1:0], {SH1{1'b0}}};
    assign c_sh2 = {c_op[W-1-SH2:0], {SH2{1'b0}}};

    always_comb begin
        unique case (PAT_SRC)
            PAT_FROM_C: pat_o = c_op;
            default:    pat_o = PAT_VAL;
        endcase
    end

    always_comb begin
        unique case (MASK_SRC)
            MSK_FROM_C:  mask_o = c_op;
            MSK_RND_SH1: mask_o = ~c_sh1;
            MSK_RND_SH2: mask_o = ~c_sh2;
            default:     mask_o = MASK_VAL;
        endcase
    end

endmodule

// File: rtl/mpat_cmp.sv
module mpat_cmp #(
    parameter int W = 48
) (
    input  logic [W-1:0] val,
    input  logic [W-1:0] pat,
    input  logic [W-1:0] mask,
    output logic         hit,
    output logic         hit_inv
);

    logic [W-1:0] bit_eq;
    logic [W-1:0] bit_eq_inv;

    // per bit: a set mask bit forces agreement for both comparisons
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic diff;
        assign diff          = val[i] ^ pat[i];
        assign bit_eq[i]     = mask[i] | ~diff;
        assign bit_eq_inv[i] = mask[i] |  diff;
    end

    assign hit     = &bit_eq;
    assign hit_inv = &bit_eq_inv;

endmodule

// File: rtl/mpat_arst_fsm.sv
module mpat_arst_fsm
    import mpat_pkg::*;
#(
    parameter clr_pol_e  CLR_POL  = CLR_NEVER,
    parameter clr_prio_e CLR_PRIO = CLR_OVER_CE
) (
    input  logic clk,
    input  logic rst,
    input  logic cep,
    input  logic hit,
    input  logic hit_inv,
    output logic match_o,
    output logic match_inv_o,
    output logic clr_req_o
);

    det_state_e st_q;
    det_state_e st_nx;
    logic       inv_q;
    logic       trig;

    // state register, with the inverse-pattern flag stored beside it
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_MISS;
            inv_q <= 1'b0;
        end else begin
            st_q <= st_nx;
            if (clr_req_o) begin
                inv_q <= 1'b0;
            end else if (cep) begin
                inv_q <= hit_inv;
            end
        end
    end

    // next state: a clear wins, then a load, else hold
    always_comb begin
        st_nx = st_q;
        if (clr_req_o) begin
            st_nx = ST_MISS;
        end else if (cep) begin
            unique case (st_q)
                ST_HIT:  st_nx = hit ? ST_HIT : ST_DROP;
                ST_MISS,
                ST_DROP: st_nx = hit ? ST_HIT : ST_MISS;
                default: st_nx = ST_MISS;
            endcase
        end
    end

    // outputs
    always_comb begin
        match_o     = (st_q == ST_HIT);
        match_inv_o = inv_q;
        unique case (CLR_POL)
            CLR_ON_MATCH: trig = (st_q == ST_HIT);
            CLR_ON_MISS:  trig = (st_q == ST_DROP);
            default:      trig = 1'b0;
        endcase
        if (CLR_PRIO == CE_GATES_CLR) begin
            clr_req_o = trig & cep;
        end else begin
            clr_req_o = trig;
        end
    end

endmodule

// File: rtl/mpat_detect.sv
module mpat_detect
    import mpat_pkg::*;
#(
    parameter int        W        = 48,
    parameter pat_src_e  PAT_SRC  = PAT_FROM_PARAM,
    parameter mask_src_e MASK_SRC = MSK_FROM_PARAM,
    parameter logic [W-1:0] PAT_VAL  = 48'h0000_0000_0000,
    parameter logic [W-1:0] MASK_VAL = 48'h3fff_ffff_ffff,
    parameter clr_pol_e  CLR_POL  = CLR_NEVER,
    parameter clr_prio_e CLR_PRIO = CLR_OVER_CE
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] acc_d,
    input  logic [W-1:0] c_op,
    input  logic         cep,
    output logic         match_o,
    output logic         match_inv_o,
    output logic         clr_req_o
);

    logic [W-1:0] pat_sel;
    logic [W-1:0] mask_sel;
    logic         hit;
    logic         hit_inv;

    mpat_src_sel #(
        .W        (W),
        .PAT_SRC  (PAT_SRC),
        .MASK_SRC (MASK_SRC),
        .PAT_VAL  (PAT_VAL),
        .MASK_VAL (MASK_VAL)
    ) u_src (
        .c_op   (c_op),
        .pat_o  (pat_sel),
        .mask_o (mask_sel)
    );

    mpat_cmp #(
        .W (W)
    ) u_cmp (
        .val     (acc_d),
        .pat     (pat_sel),
        .mask    (mask_sel),
        .hit     (hit),
        .hit_inv (hit_inv)
    );

    mpat_arst_fsm #(
        .CLR_POL  (CLR_POL),
        .CLR_PRIO (CLR_PRIO)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .cep         (cep),
        .hit         (hit),
        .hit_inv     (hit_inv),
        .match_o     (match_o),
        .match_inv_o (match_inv_o),
        .clr_req_o   (clr_req_o)
    );

endmodule

// File: rtl/mpat_detect_chk.sv
module mpat_detect_chk
    import mpat_pkg::*;
#(
    parameter clr_pol_e  CLR_POL  = CLR_NEVER,
    parameter clr_prio_e CLR_PRIO = CLR_OVER_CE
) (
    input logic clk,
    input logic rst,
    input logic cep,
    input logic match_o,
    input logic match_inv_o,
    input logic clr_req_o
);

    assert_hold_no_ce_R6: assert property (@(posedge clk) disable iff (rst)
        (!cep && !clr_req_o) |=> ($stable(match_o) && $stable(match_inv_o)));

    assert_never_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (CLR_POL == CLR_NEVER) |-> !clr_req_o);

    assert_clear_on_match_R8: assert property (@(posedge clk) disable iff (rst)
        ((CLR_POL == CLR_ON_MATCH) && match_o && ((CLR_PRIO == CLR_OVER_CE) || cep))
        |-> clr_req_o);

    assert_clear_on_miss_R9: assert property (@(posedge clk) disable iff (rst)
        ((CLR_POL == CLR_ON_MISS) && clr_req_o) |-> !match_o);

    assert_ce_gates_R10: assert property (@(posedge clk) disable iff (rst)
        ((CLR_PRIO == CE_GATES_CLR) && !cep) |-> !clr_req_o);

    assert_clear_flags_R11: assert property (@(posedge clk) disable iff (rst)
        clr_req_o |=> (!match_o && !match_inv_o));

    assert_reset_state_R12: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!match_o && !match_inv_o && !clr_req_o));

endmodule

bind mpat_detect mpat_detect_chk #(
    .CLR_POL  (CLR_POL),
    .CLR_PRIO (CLR_PRIO)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cep         (cep),
    .match_o     (match_o),
    .match_inv_o (match_inv_o),
    .clr_req_o   (clr_req_o)
);

// File: tb/mpat_detect_tb.sv
module mpat_detect_tb;
    import mpat_pkg::*;

    localparam int NW = 8;
    localparam int NK = 5;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst = 1'b1;
    logic          cep = 1'b0;
    logic [NW-1:0] acc = '0;
    logic [NW-1:0] cop = '0;
    logic [47:0]   acc48 = '0;
    logic [47:0]   cop48 = '0;

    logic m_w [NK];
    logic mb_w[NK];
    logic cr_w[NK];
    logic m48, mb48, cr48;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    int    st_m [NK];
    bit    pb_m [NK];
    string ctx_m[NK];

    // k0: static pattern and mask, clear on match, clear beats enable
    mpat_detect #(.W(NW), .PAT_SRC(PAT_FROM_PARAM), .MASK_SRC(MSK_FROM_PARAM),
        .PAT_VAL(8'h5A), .MASK_VAL(8'h0F), .CLR_POL(CLR_ON_MATCH), .CLR_PRIO(CLR_OVER_CE))
    u_dut (.clk(clk), .rst(rst), .acc_d(acc), .c_op(cop), .cep(cep),
        .match_o(m_w[0]), .match_inv_o(mb_w[0]), .clr_req_o(cr_w[0]));

    // k1: pattern from C, static mask, never clear
    mpat_detect #(.W(NW), .PAT_SRC(PAT_FROM_C), .MASK_SRC(MSK_FROM_PARAM),
        .PAT_VAL(8'h00), .MASK_VAL(8'h11), .CLR_POL(CLR_NEVER), .CLR_PRIO(CLR_OVER_CE))
    u_dut_pc (.clk(clk), .rst(rst), .acc_d(acc), .c_op(cop), .cep(cep),
        .match_o(m_w[1]), .match_inv_o(mb_w[1]), .clr_req_o(cr_w[1]));

    // k2: rounding mask shift 1, clear on first miss, enable gates clear
    mpat_detect #(.W(NW), .PAT_SRC(PAT_FROM_PARAM), .MASK_SRC(MSK_RND_SH1),
        .PAT_VAL(8'h00), .MASK_VAL(8'h00), .CLR_POL(CLR_ON_MISS), .CLR_PRIO(CE_GATES_CLR))
    u_dut_r1 (.clk(clk), .rst(rst), .acc_d(acc), .c_op(cop), .cep(cep),
        .match_o(m_w[2]), .match_inv_o(mb_w[2]), .clr_req_o(cr_w[2]));

    // k3: rounding mask shift 2, clear on first miss, clear beats enable
    mpat_detect #(.W(NW), .PAT_SRC(PAT_FROM_PARAM), .MASK_SRC(MSK_RND_SH2),
        .PAT_VAL(8'hFF), .MASK_VAL(8'h00), .CLR_POL(CLR_ON_MISS), .CLR_PRIO(CLR_OVER_CE))
    u_dut_r2 (.clk(clk), .rst(rst), .acc_d(acc), .c_op(cop), .cep(cep),
        .match_o(m_w[3]), .match_inv_o(mb_w[3]), .clr_req_o(cr_w[3]));

    // k4: mask from C, clear on match, enable gates clear
    mpat_detect #(.W(NW), .PAT_SRC(PAT_FROM_PARAM), .MASK_SRC(MSK_FROM_C),
        .PAT_VAL(8'h3C), .MASK_VAL(8'h00), .CLR_POL(CLR_ON_MATCH), .CLR_PRIO(CE_GATES_CLR))
    u_dut_mc (.clk(clk), .rst(rst), .acc_d(acc), .c_op(cop), .cep(cep),
        .match_o(m_w[4]), .match_inv_o(mb_w[4]), .clr_req_o(cr_w[4]));

    // full width, all defaults
    mpat_detect u_dut_def (.clk(clk), .rst(rst), .acc_d(acc48), .c_op(cop48), .cep(cep),
        .match_o(m48), .match_inv_o(mb48), .clr_req_o(cr48));

    task automatic chk(string tag, logic [47:0] act, logic [47:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    function automatic logic [NW-1:0] pat_of(int k, logic [NW-1:0] c);
        case (k)
            0: return 8'h5A;
            1: return c;
            2: return 8'h00;
            3: return 8'hFF;
            default: return 8'h3C;
        endcase
    endfunction

    function automatic logic [NW-1:0] msk_of(int k, logic [NW-1:0] c);
        logic [NW-1:0] t;
        case (k)
            0: return 8'h0F;
            1: return 8'h11;
            2: begin t = c << 1; return ~t; end
            3: begin t = c << 2; return ~t; end
            default: return c;
        endcase
    endfunction

    function automatic int pol_of(int k); // 0 never, 1 on match, 2 on first miss
        case (k)
            0, 4: return 1;
            2, 3: return 2;
            default: return 0;
        endcase
    endfunction

    function automatic bit gated_of(int k);
        return (k == 2) || (k == 4);
    endfunction

    function automatic bit exp_clr(int k, bit ce);
        bit t;
        case (pol_of(k))
            1: t = (st_m[k] == 1);
            2: t = (st_m[k] == 2);
            default: t = 1'b0;
        endcase
        return t && (!gated_of(k) || ce);
    endfunction

    // drive one cycle at the falling edge, check registered state, advance model
    task automatic step(bit r, bit ce, logic [NW-1:0] v, logic [NW-1:0] c);
        @(negedge clk);
        rst = r; cep = ce; acc = v; cop = c;
        #1;
        for (int k = 0; k < NK; k++) begin
            string td, tc;
            if (ctx_m[k] != "") td = ctx_m[k];
            else if (k == 0) td = "R1";
            else if (k == 1) td = "R3";
            else td = "R4";
            chk(td, m_w[k], (st_m[k] == 1));
            chk((ctx_m[k] != "") ? ctx_m[k] : "R2", mb_w[k], pb_m[k]);
            if (gated_of(k) && !ce) tc = "R10";
            else if (pol_of(k) == 0) tc = "R7";
            else if (pol_of(k) == 1) tc = "R8";
            else tc = "R9";
            chk(tc, cr_w[k], exp_clr(k, ce));
        end
        for (int k = 0; k < NK; k++) begin
            bit cl, hm, hb;
            logic [NW-1:0] p, mk;
            cl = exp_clr(k, ce);
            p  = pat_of(k, c);
            mk = msk_of(k, c);
            hm = (((v ^ p) & ~mk) == '0);
            hb = (((v ^ ~p) & ~mk) == '0);
            if (r) begin
                st_m[k] = 0; pb_m[k] = 1'b0; ctx_m[k] = "R12";
            end else if (cl) begin
                st_m[k] = 0; pb_m[k] = 1'b0; ctx_m[k] = "R11";
            end else if (ce) begin
                st_m[k] = hm ? 1 : ((st_m[k] == 1) ? 2 : 0);
                pb_m[k] = hb;
                ctx_m[k] = "";
            end else begin
                ctx_m[k] = "R6";
            end
        end
    endtask

    initial begin
        for (int k = 0; k < NK; k++) begin
            st_m[k] = 0; pb_m[k] = 1'b0; ctx_m[k] = "R12";
        end
        repeat (2) @(posedge clk);
        // sweep: every accumulator value against 16 C values, rhythmic enable drops
        for (int ci = 0; ci < 16; ci++) begin
            for (int v = 0; v < 256; v++) begin
                bit r, ce;
                r  = (ci == 8) && (v == 0);
                ce = ((v % 5) != 2);
                step(r, ce, v[NW-1:0], 8'(ci * 17));
            end
        end
        // defaults: only bits 47:46 compared, pattern zero
        @(negedge clk); rst = 1'b0; cep = 1'b1; acc48 = 48'h0012_3456_789A;
        @(negedge clk); chk("R5", m48, 1'b1); chk("R5", mb48, 1'b0);
        acc48 = 48'h4000_0000_0000;
        @(negedge clk); chk("R5", m48, 1'b0); chk("R5", mb48, 1'b0);
        acc48 = 48'hC0FF_0000_0001;
        @(negedge clk); chk("R5", m48, 1'b0); chk("R5", mb48, 1'b1); chk("R7", cr48, 1'b0);
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog (all): actual running expected finished");
            summary();
            $finish;
        end
    end

endmodule